// File: doc/BRIEF.md
# Absmean Ternary Weight Quantizer

This block turns a tensor of signed fixed-point weights into ternary codes, one code per weight, using the mean absolute value of the whole tensor as the scale. It works on a stream of weights in two passes. In the summing pass every weight of the tensor enters once, and the block adds up the magnitudes. On the pass's last beat it divides the total by the element count to form the scale. In the emitting pass the same weights enter again in any order, and the block returns one 2-bit code for each of them. The scale stays on its own port so that a later stage can rescale.

The element count is a power-of-two parameter, so the division is a right shift. A weight becomes its own sign when twice its magnitude reaches the scale plus a small positive bias; otherwise it becomes zero. This comparison performs round-to-nearest followed by a clip to one, and it needs no divider. The bias keeps an all-zero tensor from producing nonzero codes. An input pass select tells the block which pass a beat belongs to. The block holds its ready low for beats of the wrong pass.

Top module: `absmean_ternarizer`

## Requirements
- R1: After reset the block is in the summing phase: `inReady` equals `!inPass`, `outValid` is 0 and `outScale` is 0.
- R2: A beat accepted in the summing pass (`inPass`=0) never produces an output; `outValid` is 0 in the following cycle.
- R3: On the clock edge that accepts the summing-pass beat with `inLast`=1, `outScale` becomes floor(sum of |w| over the tensor / N_ELEMS) (that beat included). It then holds its value until the next such edge.
- R4: An emitting-pass weight w gives code 2'b01 (+1) when w>0 and 2·|w| ≥ scale+EPS, code 2'b11 (-1) when w<0 and 2·|w| ≥ scale+EPS, and code 2'b00 (0) otherwise. An exact tie rounds away from zero.
- R5: Each beat accepted in the emitting pass (`inPass`=1) produces exactly one code with `outValid`=1 in the next cycle, and `outLast` in that cycle equals the beat's `inLast`.
- R6: In the summing phase, beats marked `inPass`=1 see `inReady`=0, and so do beats marked `inPass`=0 in the emitting phase. A rejected beat changes neither the outputs nor the running sum.
- R7: An all-zero tensor yields scale 0 and every code 2'b00.
- R8: The most negative input value counts as magnitude 2^(W_BITS-1). A tensor that holds only that value yields scale 2^(W_BITS-1), every code 2'b11, and no accumulator overflow.
- R9: After the emitting-pass beat with `inLast`=1, the block returns to the summing phase, and the sum for the next tensor starts from zero.
- R10: The code 2'b10 never appears while `outValid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Weight beat present |
| inReady | output | 1 | Block accepts the beat |
| inPass | input | 1 | 0 = summing pass, 1 = emitting pass |
| inLast | input | 1 | Final beat of the pass |
| inData | input | W_BITS | Signed weight |
| outValid | output | 1 | Code present |
| outCode | output | 2 | Ternary code: 00=0, 01=+1, 11=-1 |
| outLast | output | 1 | Code belongs to the final weight |
| outScale | output | W_BITS | Unsigned mean absolute value of the last summed tensor |

## Verification
Suppose the running sum is corrupted, or is not cleared between tensors. Then `outScale` is wrong one cycle after the summing pass's last beat. Because every code is compared against that scale, weights near the threshold then come out with the wrong codes. A wrong phase register shows up at once as an `inReady` that contradicts `inPass`. It can also show up as codes during the summing pass, or as missing codes one cycle after emitting-pass beats. An error in the magnitude or threshold path is visible on the first weight whose doubled magnitude falls near the scale, for example an exact tie or the most negative value.

// File: rtl/tern_pkg.sv
package tern_pkg;
  typedef enum logic {PH_SUM = 1'b0, PH_EMIT = 1'b1} phase_t;

  typedef struct packed {
    logic accum;     // add magnitude of accepted summing beat
    logic latch;     // final summing beat: store scale, clear sum
    logic emit;      // accepted emitting beat: register a code
    logic emitLast;  // emitting beat carries the last flag
  } strobe_t;

  localparam logic [1:0] CODE_ZERO = 2'b00;
  localparam logic [1:0] CODE_POS  = 2'b01;
  localparam logic [1:0] CODE_NEG  = 2'b11;
endpackage

// File: rtl/tern_ctrl.sv
module tern_ctrl
  import tern_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    inPass,
  input  logic    inLast,
  output logic    inReady,
  output strobe_t strobe
);
  phase_t phase;
  logic   fire;

  always_comb begin
    inReady = (phase == PH_SUM) ? !inPass : inPass;
    fire    = inValid && inReady;
    strobe.accum    = fire && (phase == PH_SUM);
    strobe.latch    = fire && (phase == PH_SUM) && inLast;
    strobe.emit     = fire && (phase == PH_EMIT);
    strobe.emitLast = fire && (phase == PH_EMIT) && inLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_SUM;
    end else if (strobe.latch) begin
      phase <= PH_EMIT;
    end else if (strobe.emitLast) begin
      phase <= PH_SUM;
    end
  end
endmodule

// File: rtl/tern_datapath.sv
module tern_datapath
  import tern_pkg::*;
#(
  parameter int W_BITS  = 8,
  parameter int N_ELEMS = 16,
  parameter int EPS     = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [W_BITS-1:0] inData,
  output logic              outValid,
  output logic [1:0]        outCode,
  output logic              outLast,
  output logic [W_BITS-1:0] outScale
);
  localparam int LOG2N = $clog2(N_ELEMS);
  localparam int ACC_W = W_BITS + LOG2N;
  localparam int CMP_W = W_BITS + 2;

  logic              isNeg;
  logic [W_BITS-1:0] magW;
  logic [ACC_W-1:0]  sumReg;
  logic [ACC_W-1:0]  sumNext;
  logic [ACC_W-1:0]  meanFull;
  logic [CMP_W-1:0]  thresh;
  logic [CMP_W-1:0]  dblMag;
  logic              reaches;
  logic [1:0]        codeNext;

  always_comb begin
    isNeg    = inData[W_BITS-1];
    magW     = isNeg ? (~inData + 1'b1) : inData;
    sumNext  = sumReg + ACC_W'(magW);
    meanFull = sumNext >> LOG2N;
    thresh   = {2'b00, outScale} + CMP_W'(EPS);
    dblMag   = {1'b0, magW, 1'b0};
    reaches  = dblMag >= thresh;
    if (!reaches)   codeNext = CODE_ZERO;
    else if (isNeg) codeNext = CODE_NEG;
    else            codeNext = CODE_POS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumReg   <= '0;
      outScale <= '0;
    end else if (strobe.latch) begin
      sumReg   <= '0;
      outScale <= meanFull[W_BITS-1:0];
    end else if (strobe.accum) begin
      sumReg   <= sumNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outCode  <= CODE_ZERO;
      outLast  <= 1'b0;
    end else begin
      outValid <= strobe.emit;
      outCode  <= strobe.emit ? codeNext : CODE_ZERO;
      outLast  <= strobe.emitLast;
    end
  end
endmodule

// File: rtl/absmean_ternarizer.sv
module absmean_ternarizer
  import tern_pkg::*;
#(
  parameter int W_BITS  = 8,
  parameter int N_ELEMS = 16,
  parameter int EPS     = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic              inPass,
  input  logic              inLast,
  input  logic [W_BITS-1:0] inData,
  output logic              outValid,
  output logic [1:0]        outCode,
  output logic              outLast,
  output logic [W_BITS-1:0] outScale
);
  strobe_t strobe;

  tern_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .inPass (inPass),
    .inLast (inLast),
    .inReady(inReady),
    .strobe (strobe)
  );

  tern_datapath #(
    .W_BITS (W_BITS),
    .N_ELEMS(N_ELEMS),
    .EPS    (EPS)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inData  (inData),
    .outValid(outValid),
    .outCode (outCode),
    .outLast (outLast),
    .outScale(outScale)
  );
endmodule

// File: rtl/tern_checker.sv
module tern_checker #(
  parameter int W_BITS = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              inPass,
  input logic              inLast,
  input logic [W_BITS-1:0] inData,
  input logic              outValid,
  input logic [1:0]        outCode,
  input logic              outLast,
  input logic [W_BITS-1:0] outScale
);
  logic inEmitPhase;  // independent phase tracker from handshakes
  always_ff @(posedge clk) begin
    if (!rstN) inEmitPhase <= 1'b0;
    else if (inValid && inReady && !inPass && inLast) inEmitPhase <= 1'b1;
    else if (inValid && inReady && inPass && inLast) inEmitPhase <= 1'b0;
  end

  assert_no_out_in_sum_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !inPass) |=> !outValid);

  assert_scale_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inReady && !inPass && inLast) |=> $stable(outScale));

  assert_pos_sign_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCode == 2'b01) |-> !$past(inData[W_BITS-1]));

  assert_neg_sign_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCode == 2'b11) |-> $past(inData[W_BITS-1]));

  assert_code_from_beat_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid && inReady && inPass));

  assert_last_copy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inPass) |=> (outValid && outLast == $past(inLast)));

  assert_reject_wrong_pass_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inEmitPhase != inPass) |-> !inReady);

  assert_code_legal_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outCode != 2'b10);
endmodule

bind absmean_ternarizer tern_checker #(.W_BITS(W_BITS)) i_tern_checker (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inReady (inReady),
  .inPass  (inPass),
  .inLast  (inLast),
  .inData  (inData),
  .outValid(outValid),
  .outCode (outCode),
  .outLast (outLast),
  .outScale(outScale)
);

// File: tb/test_absmean_ternarizer.sv
module test_absmean_ternarizer;
  localparam int W  = 8;
  localparam int N  = 16;
  localparam int EP = 1;
  localparam int NV = 5;

  // stimulus tensor (element i = bits [i*8 +: 8]) and expected scale
  localparam logic [N*W-1:0] TV_DATA [NV] = '{
    128'h03_00_80_7f_f8_08_e0_20_ff_01_c0_40_fb_05_f0_10,
    128'h00_00_00_00_00_00_00_00_00_00_00_00_00_00_00_00,
    128'h80_80_80_80_80_80_80_80_80_80_80_80_80_80_80_80,
    128'h0f_0e_0d_0c_0b_0a_09_08_07_06_05_04_03_02_01_00,
    128'h01_ff_01_ff_01_ff_01_ff_01_ff_01_ff_01_ff_01_7f
  };
  localparam logic [W-1:0] TV_SCALE [NV] = '{8'd31, 8'd0, 8'd128, 8'd7, 8'd8};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inPass = 1'b0, inLast = 1'b0;
  logic [W-1:0] inData = '0;
  logic inReady, outValid, outLast;
  logic [1:0] outCode;
  logic [W-1:0] outScale;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  absmean_ternarizer #(.W_BITS(W), .N_ELEMS(N), .EPS(EP)) i_absmean_ternarizer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inPass(inPass), .inLast(inLast), .inData(inData), .outValid(outValid),
    .outCode(outCode), .outLast(outLast), .outScale(outScale)
  );

  function automatic logic [1:0] refCode(input logic [W-1:0] w, input int scale);
    int v, m;
    v = $signed(w);
    m = (v < 0) ? -v : v;
    if (2 * m < scale + EP) return 2'b00;
    return (v < 0) ? 2'b11 : 2'b01;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one beat at negedge; sample results at the following negedge
  task automatic beat(input logic pass, input logic last, input logic [W-1:0] d);
    @(negedge clk);
    inValid = 1'b1; inPass = pass; inLast = last; inData = d;
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ready", inReady, 1);
    check("R1 valid", outValid, 0);
    check("R1 scale", outScale, 0);
    rstN = 1'b1;

    // R6: emitting beat before any summing pass is rejected
    @(negedge clk);
    inValid = 1'b1; inPass = 1'b1; inData = 8'h7f;
    #1 check("R6 ready low early", inReady, 0);
    @(negedge clk);
    check("R6 no output", outValid, 0);
    inValid = 1'b0;

    for (int t = 0; t < NV; t++) begin
      for (int i = 0; i < N; i++) begin
        beat(1'b0, i == N - 1, TV_DATA[t][i*W +: W]);
        check("R2 silent summing", outValid, 0);
        if (t == 0 && i == 2) begin
          // R6 mid-pass reject, sum must be unaffected
          inValid = 1'b1; inPass = 1'b1; inData = 8'h7f;
          #1 check("R6 ready low mid", inReady, 0);
          @(negedge clk);
          check("R6 no output mid", outValid, 0);
          inValid = 1'b0;
        end
      end
      check("R3/R9 scale", outScale, TV_SCALE[t]);
      if (t == 1) begin
        // R6: summing beat during emitting phase rejected
        inValid = 1'b1; inPass = 1'b0; inData = 8'h40;
        #1 check("R6 ready low emit", inReady, 0);
        @(negedge clk);
        inValid = 1'b0;
      end
      for (int i = 0; i < N; i++) begin
        logic [1:0] exp;
        exp = refCode(TV_DATA[t][i*W +: W], TV_SCALE[t]);
        beat(1'b1, i == N - 1, TV_DATA[t][i*W +: W]);
        check("R5 valid", outValid, 1);
        check("R5 last", outLast, (i == N - 1) ? 1 : 0);
        check("R4 code", outCode, exp);
        check("R10 legal", (outCode == 2'b10) ? 1 : 0, 0);
        if (t == 1) check("R7 zero code", outCode, 0);
        if (t == 2) check("R8 min code", outCode, 3);
        if (t == 3 && i == 4) check("R4 tie away", outCode, 1);
        if (t == 4 && i == 1) check("R4 below threshold", outCode, 0);
      end
      @(negedge clk);
      check("R9 back to summing", inReady, inPass ? 0 : 1);
      check("R3 scale held", outScale, TV_SCALE[t]);
    end
    check("R7 zero scale", TV_SCALE[1], 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule